// File: doc/BRIEF.md
# Frame-Word Pixel Unpacker with Colour Lookup

This block sits between a frame-memory fetch engine and a display pipeline. It accepts 32-bit words of packed frame data, one at a time, with a valid/ready handshake, and emits one pixel per handshake as a 16-bit 5:6:5 colour. A three-bit depth code chooses one of eight packing formats. Four of them carry colour indices into a 256-entry colour table. The others carry colour directly at 12, 16 or 24 bits. Two ordering controls cover byte-swapped words and most-significant-first packing of sub-byte pixels. A final control exchanges the red and blue fields of every output pixel.

The colour table is loaded and read back through a simple register port. Each 32-bit location holds two neighbouring entries. The depth code, both ordering controls and the swap control are sampled when a word is accepted and apply to every pixel of that word. The bench changes them only while no word is in flight.

Top module: `pix_unpack`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `in_ready` is 1 and every colour-table entry reads back as zero.
- R2: `cfg_depth` selects how many pixels one word yields. 0 gives 32 pixels of 1 bit, 1 gives 16 of 2 bits, 2 gives 8 of 4 bits and 3 gives 4 of 8 bits. 4 (1:5:5:5), 6 (5:6:5) and 7 (4:4:4) give 2 pixels of 16 bits each. 5 gives 1 pixel of 24 bits. After the last pixel is taken, `out_valid` drops unless a new word arrives.
- R3: At depth codes 0 to 3, the pixel value is an index into the colour table, and the output is that table entry converted as in R4.
- R4: A 16-bit colour in table format has red in bits 4:0, green in bits 9:5, blue in bits 14:10 and bit 15 as the green LSB. The 6-bit green is {bits 9:5, bit 15}. Depth code 4 reads pixels in this same format directly.
- R5: Depth code 6 reads 16-bit pixels with red in bits 4:0, green in bits 10:5 and blue in bits 15:11.
- R6: Depth code 5 uses the low 24 bits of the word: red in 7:0, green in 15:8, blue in 23:16. Each channel is cut to its top 5, 6 and 5 bits.
- R7: Depth code 7 reads 16-bit pixels with red in 3:0, green in 7:4 and blue in 11:8, and ignores bits 15:12. Each channel is widened by copying its top bits into the missing low bits: red and blue gain one bit, green gains two.
- R8: With `cfg_byte_be` = 1, the word's bytes are reversed before unpacking, so byte k becomes `in_word[8*(3-k)+7 : 8*(3-k)]`. Pixels are then taken from byte/bit position 0 upward.
- R9: For pixels narrower than a byte, with `cfg_pix_be` = 0 pixel j of a byte sits in its lowest bits first. With `cfg_pix_be` = 1 pixel j occupies bits (7-j*w) down to (8-(j+1)*w), where w is the pixel width.
- R10: The output places red in bits 4:0, green in 10:5 and blue in 15:11 when `cfg_swap_rb` = 0. When it is 1, red and blue exchange positions.
- R11: While `out_valid` = 1 and `out_ready` = 0, the output pixel stays unchanged, `in_ready` stays 0 and no pixel is dropped.
- R12: A write with `pal_we` stores `pal_wdata[15:0]` in entry 2*`pal_addr` and `pal_wdata[31:16]` in entry 2*`pal_addr`+1. `pal_rdata` presents both entries, in the same layout, one cycle after the address, showing contents from before any write in that same cycle.
- R13: A word accepted at a clock edge shows its first pixel right after that edge. `in_ready` is 1 while the last pixel of a word is being taken, so words follow each other without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_byte_be | input | 1 | Reverse byte order of the word |
| cfg_pix_be | input | 1 | Sub-byte pixels packed from the top of each byte |
| cfg_swap_rb | input | 1 | Exchange red and blue on output |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed frame word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 16 | 5:6:5 colour |
| pal_we | input | 1 | Colour-table write strobe |
| pal_addr | input | 7 | Colour-table pair address |
| pal_wdata | input | 32 | Two entries to write |
| pal_rdata | output | 32 | Two entries read back |

## Verification
The datapath has a single register stage. A word taken at an edge shows its first pixel right after that edge, and each pixel taken with `out_ready` high is replaced at that same edge. The bench therefore drives and compares on the falling edge that follows each rising edge. Colour-table readback lags its address by one edge, so each readback check comes one falling edge after a cycle with `pal_we` low. During stalls, the pixel and `in_ready` are checked on every stalled cycle, and the transfer is then resumed to confirm that no pixel was skipped.

// File: rtl/pxu_pkg.sv
// Package for the pixel unpacker: depth codes, per-depth geometry and the
// shared decode of the 1:5:5:5 table format. Assumes 32-bit input words.
package pxu_pkg;

    typedef enum logic [2:0] {
        DEP_1    = 3'd0,
        DEP_2    = 3'd1,
        DEP_4    = 3'd2,
        DEP_8    = 3'd3,
        DEP_1555 = 3'd4,
        DEP_24   = 3'd5,
        DEP_565  = 3'd6,
        DEP_444  = 3'd7
    } depth_e;

    typedef struct packed {
        logic [4:0] b;
        logic [5:0] g;
        logic [4:0] r;
    } rgb_t;

    // Bits one pixel occupies in the word (24-bit pixels use a whole word)
    function automatic logic [5:0] pix_bits(depth_e d);
        case (d)
            DEP_1:   return 6'd1;
            DEP_2:   return 6'd2;
            DEP_4:   return 6'd4;
            DEP_8:   return 6'd8;
            DEP_24:  return 6'd32;
            default: return 6'd16;
        endcase
    endfunction

    // Index of the last pixel inside one word
    function automatic logic [4:0] last_pix(depth_e d);
        case (d)
            DEP_1:   return 5'd31;
            DEP_2:   return 5'd15;
            DEP_4:   return 5'd7;
            DEP_8:   return 5'd3;
            DEP_24:  return 5'd0;
            default: return 5'd1;
        endcase
    endfunction

    function automatic logic is_indexed(depth_e d);
        return (d == DEP_1) || (d == DEP_2) || (d == DEP_4) || (d == DEP_8);
    endfunction

    // Table format: bit 15 green LSB, 14:10 blue, 9:5 green, 4:0 red
    function automatic rgb_t from_1555(logic [15:0] e);
        rgb_t c;
        c.r = e[4:0];
        c.g = {e[9:5], e[15]};
        c.b = e[14:10];
        return c;
    endfunction

endpackage

// File: rtl/pxu_palette.sv
// Colour table: 2**IDX_W entries of 16 bits, cleared by reset.
// Register port works on pairs of entries (one 32-bit location per pair);
// readback is registered, pixel lookup is combinational.
module pxu_palette #(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-2:0]   addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [IDX_W-1:0]   pix_idx,
    output logic [15:0]        pix_entry
);
    localparam int DEPTH = 1 << IDX_W;

    logic [15:0] mem [DEPTH];

    // Storage: clear on reset, write both entries of a pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[{addr, 1'b0}] <= wdata[15:0];
            mem[{addr, 1'b1}] <= wdata[31:16];
        end
    end

    // Register readback of the addressed pair (pre-write contents)
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= {mem[{addr, 1'b1}], mem[{addr, 1'b0}]};
    end

    // Combinational lookup for the pixel path
    always_comb pix_entry = mem[pix_idx];

endmodule

// File: rtl/pxu_select.sv
// Picks pixel number idx out of a held word for the given depth and
// ordering controls. Purely combinational; returns the raw field,
// zero-extended to 24 bits.
module pxu_select
    import pxu_pkg::*;
(
    input  logic [31:0] word,
    input  depth_e      depth,
    input  logic        byte_be,
    input  logic        pix_be,
    input  logic [4:0]  idx,
    output logic [23:0] raw
);
    logic [31:0] ordered;
    logic [5:0]  bits;
    logic [9:0]  prod;
    logic [4:0]  off;
    logic [31:0] shifted;
    logic [23:0] mask;

    // Byte reordering of the whole word
    always_comb begin
        for (int k = 0; k < 4; k++)
            ordered[8*k +: 8] = byte_be ? word[8*(3-k) +: 8] : word[8*k +: 8];
    end

    // Bit offset of the pixel, mirrored inside the byte for sub-byte packing
    always_comb begin
        bits = pix_bits(depth);
        prod = {5'd0, idx} * {4'd0, bits};
        off  = prod[4:0];
        if (pix_be && (bits < 6'd8))
            off = off ^ (5'd8 - bits[4:0]);
    end

    // Field extraction and width masking
    always_comb begin
        shifted = ordered >> off;
        case (bits)
            6'd1:    mask = 24'h000001;
            6'd2:    mask = 24'h000003;
            6'd4:    mask = 24'h00000F;
            6'd8:    mask = 24'h0000FF;
            6'd16:   mask = 24'h00FFFF;
            default: mask = 24'hFFFFFF;
        endcase
        raw = shifted[23:0] & mask;
    end

endmodule

// File: rtl/pxu_convert.sv
// Turns a raw pixel field (or its colour-table entry) into a 5:6:5
// output, then applies the red/blue exchange. Combinational.
module pxu_convert
    import pxu_pkg::*;
(
    input  logic [23:0] raw,
    input  depth_e      depth,
    input  logic        swap_rb,
    input  logic [15:0] pal_entry,
    output logic [15:0] pixel
);
    rgb_t c;

    // Per-format channel decode and widening/truncation
    always_comb begin
        case (depth)
            DEP_1, DEP_2, DEP_4, DEP_8: c = from_1555(pal_entry);
            DEP_1555: c = from_1555(raw[15:0]);
            DEP_565: begin
                c.r = raw[4:0];
                c.g = raw[10:5];
                c.b = raw[15:11];
            end
            DEP_24: begin
                c.r = raw[7:3];
                c.g = raw[15:10];
                c.b = raw[23:19];
            end
            default: begin
                c.r = {raw[3:0], raw[3]};
                c.g = {raw[7:4], raw[7:6]};
                c.b = {raw[11:8], raw[11]};
            end
        endcase
    end

    // Output packing with optional red/blue exchange
    always_comb pixel = swap_rb ? {c.r, c.g, c.b} : {c.b, c.g, c.r};

endmodule

// File: rtl/pix_unpack.sv
// Top of the pixel unpacker. Holds one input word plus its sampled
// configuration and walks through its pixels, one per output handshake.
// Assumes the cfg_* inputs are stable when a word is offered.
module pix_unpack
    import pxu_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_depth,
    input  logic               cfg_byte_be,
    input  logic               cfg_pix_be,
    input  logic               cfg_swap_rb,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [31:0]        in_word,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [15:0]        out_pixel,
    input  logic               pal_we,
    input  logic [IDX_W-2:0]   pal_addr,
    input  logic [31:0]        pal_wdata,
    output logic [31:0]        pal_rdata
);
    logic [31:0] word_q;
    depth_e      depth_q;
    logic        byte_be_q, pix_be_q, swap_q;
    logic        busy;
    logic [4:0]  idx;
    logic        last;
    logic [23:0] raw;
    logic [15:0] entry;

    // Handshake decode
    always_comb begin
        last      = (idx == last_pix(depth_q));
        out_valid = busy;
        in_ready  = !busy || (out_ready && last);
    end

    // Word holding register, sampled configuration and pixel counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            idx       <= '0;
            word_q    <= '0;
            depth_q   <= DEP_1;
            byte_be_q <= 1'b0;
            pix_be_q  <= 1'b0;
            swap_q    <= 1'b0;
        end else if (in_valid && in_ready) begin
            busy      <= 1'b1;
            idx       <= '0;
            word_q    <= in_word;
            depth_q   <= depth_e'(cfg_depth);
            byte_be_q <= cfg_byte_be;
            pix_be_q  <= cfg_pix_be;
            swap_q    <= cfg_swap_rb;
        end else if (busy && out_ready) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + 5'd1;
        end
    end

    pxu_select u_sel (
        .word    (word_q),
        .depth   (depth_q),
        .byte_be (byte_be_q),
        .pix_be  (pix_be_q),
        .idx     (idx),
        .raw     (raw)
    );

    pxu_palette #(.IDX_W(IDX_W)) u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pal_we),
        .addr      (pal_addr),
        .wdata     (pal_wdata),
        .rdata     (pal_rdata),
        .pix_idx   (raw[IDX_W-1:0]),
        .pix_entry (entry)
    );

    pxu_convert u_cvt (
        .raw       (raw),
        .depth     (depth_q),
        .swap_rb   (swap_q),
        .pal_entry (entry),
        .pixel     (out_pixel)
    );

endmodule

// File: rtl/pxu_checker.sv
// Handshake properties of the pixel unpacker, bound to the top.
module pxu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_pixel,
    input logic        pal_we
);
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !pal_we) |=> (out_valid && $stable(out_pixel)))
        else $error("stalled pixel changed or dropped");

    p_stall_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)
        else $error("word accepted during stall");

    p_idle_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready)
        else $error("idle but not ready");

    p_accept_show_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid)
        else $error("accepted word not shown next cycle");

endmodule

bind pix_unpack pxu_checker u_pxu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .pal_we    (pal_we)
);

// File: tb/pix_unpack_test.sv
module pix_unpack_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_depth = '0;
    logic        cfg_byte_be = 1'b0, cfg_pix_be = 1'b0, cfg_swap_rb = 1'b0;
    logic        in_valid = 1'b0, out_ready = 1'b0, pal_we = 1'b0;
    logic        in_ready, out_valid;
    logic [31:0] in_word = '0, pal_wdata = '0, pal_rdata;
    logic [15:0] out_pixel;
    logic [6:0]  pal_addr = '0;

    int total = 0, fails = 0;
    bit done = 0;
    logic [15:0] pal_m [256];

    always #(CLK_P/2) clk = ~clk;

    pix_unpack uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(int i);
        return 16'((i * 40503) ^ 23130);
    endfunction

    // Reference from the requirement text
    function automatic logic [15:0] model(logic [31:0] wd, int dep, bit bbe, bit pbe, bit sw, int n);
        logic [7:0]  by [4];
        logic [15:0] h;
        logic [4:0]  r, b;
        logic [5:0]  g;
        int bits, ppb, j, sh, v;
        for (int k = 0; k < 4; k++) by[k] = bbe ? wd[8*(3-k) +: 8] : wd[8*k +: 8];
        h = {by[2*(n%2)+1], by[2*(n%2)]};
        if (dep <= 3) begin
            bits = 1 << dep;
            if (bits == 8) v = by[n];
            else begin
                ppb = 8 / bits; j = n % ppb;
                sh = pbe ? 8 - bits*(j+1) : bits*j;
                v = (int'(by[n/ppb]) >> sh) & ((1 << bits) - 1);
            end
            h = pal_m[v];
        end
        case (dep)
            5: begin r = by[0][7:3]; g = by[1][7:2]; b = by[2][7:3]; end
            6: begin r = h[4:0]; g = h[10:5]; b = h[15:11]; end
            7: begin r = {h[3:0], h[3]}; g = {h[7:4], h[7:6]}; b = {h[11:8], h[11]}; end
            default: begin r = h[4:0]; g = {h[9:5], h[15]}; b = h[14:10]; end
        endcase
        return sw ? {r, g, b} : {b, g, r};
    endfunction

    function automatic int npix(int dep);
        if (dep == 5) return 1;
        if (dep >= 4) return 2;
        return 32 >> dep;
    endfunction

    // Send one word and check every pixel and the end of the word (R2)
    task automatic run_word(string tag, logic [31:0] wd, int dep, bit bbe, bit pbe, bit sw);
        @(negedge clk);
        cfg_depth = 3'(dep); cfg_byte_be = bbe; cfg_pix_be = pbe; cfg_swap_rb = sw;
        in_word = wd; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < npix(dep); k++) begin
            check(tag, {15'd0, out_valid, out_pixel}, {15'd0, 1'b1, model(wd, dep, bbe, pbe, sw, k)});
            @(negedge clk);
        end
        check({"R2 end ", tag}, {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd1);
        check("R1 table clear", pal_rdata, 32'd0);
    endtask

    task automatic t_table_port;
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            pal_we = 1'b1; pal_addr = 7'(a); pal_wdata = {pat(2*a+1), pat(2*a)};
            pal_m[2*a] = pat(2*a); pal_m[2*a+1] = pat(2*a+1);
        end
        @(negedge clk); pal_we = 1'b0; pal_addr = 7'd77;
        @(negedge clk);
        check("R12 readback pair", pal_rdata, {pat(155), pat(154)});
        pal_we = 1'b1; pal_addr = 7'd5; pal_wdata = 32'hBEEF_1234;
        pal_m[10] = 16'h1234; pal_m[11] = 16'hBEEF;
        @(negedge clk);
        check("R12 pre-write read", pal_rdata, {pat(11), pat(10)});
        pal_we = 1'b0;
        @(negedge clk);
        check("R12 post-write read", pal_rdata, 32'hBEEF_1234);
    endtask

    task automatic t_indexed;
        run_word("R3 1bpp", 32'hA5C3_0F96, 0, 0, 0, 0);
        run_word("R3 2bpp", 32'h1B6E_D427, 1, 0, 0, 0);
        run_word("R3 4bpp", 32'hFEDC_0A5B, 2, 0, 0, 0);
        run_word("R3 8bpp", 32'h0B0A_80FF, 3, 0, 0, 0);
    endtask

    task automatic t_orders;
        run_word("R9 1bpp top-first", 32'h8001_C3A5, 0, 0, 1, 0);
        run_word("R9 2bpp top-first", 32'h1B2D_E4C6, 1, 0, 1, 0);
        run_word("R9 4bpp top-first", 32'h12AB_34CD, 2, 0, 1, 0);
        run_word("R8 8bpp swapped", 32'h0102_0304, 3, 1, 0, 0);
        run_word("R8 565 swapped", 32'hF81F_07E0, 6, 1, 0, 0);
        run_word("R8 R9 4bpp both", 32'h9C3E_51A7, 2, 1, 1, 0);
    endtask

    task automatic t_direct;
        run_word("R4 1555 green lsb", 32'h7FFF_8000, 4, 0, 0, 0);
        run_word("R4 1555 mixed", 32'hC21F_3E41, 4, 0, 0, 0);
        run_word("R5 565", 32'h07E0_F81F, 6, 0, 0, 0);
        run_word("R6 24bpp", 32'hAB_F8FC07, 5, 0, 0, 0);
        run_word("R6 24bpp swapped bytes", 32'h1F8E_C700, 5, 1, 0, 0);
        run_word("R7 444", 32'hF8A3_0C5F, 7, 0, 0, 0);
    endtask

    task automatic t_swap;
        run_word("R10 565 swap", 32'h07E0_F81F, 6, 0, 0, 1);
        run_word("R10 8bpp swap", 32'h0B0A_80FF, 3, 0, 0, 1);
    endtask

    task automatic t_stall;
        logic [31:0] wd = 32'h4321_76FE;
        @(negedge clk);
        cfg_depth = 3'd3; cfg_byte_be = 0; cfg_pix_be = 0; cfg_swap_rb = 0;
        in_word = wd; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_word = 32'h5555_5555;
        for (int c = 0; c < 3; c++) begin
            check("R11 held pixel", {15'd0, out_valid, out_pixel}, {15'd0, 1'b1, model(wd, 3, 0, 0, 0, 0)});
            check("R11 in_ready low", {31'd0, in_ready}, 32'd0);
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check("R11 no pixel lost", {15'd0, out_valid, out_pixel}, {15'd0, 1'b1, model(wd, 3, 0, 0, 0, k)});
            @(negedge clk);
        end
        check("R11 word done", {31'd0, out_valid}, 32'd0);
    endtask

    task automatic t_back_to_back;
        logic [31:0] wa = 32'h00_123456, wb = 32'h00_FEDCBA;
        @(negedge clk);
        cfg_depth = 3'd5; cfg_byte_be = 0; cfg_pix_be = 0; cfg_swap_rb = 0;
        in_word = wa; in_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        check("R13 first pixel next cycle", {15'd0, out_valid, out_pixel}, {15'd0, 1'b1, model(wa, 5, 0, 0, 0, 0)});
        check("R13 ready on last pixel", {31'd0, in_ready}, 32'd1);
        in_word = wb;
        @(negedge clk);
        in_valid = 1'b0;
        check("R13 no gap", {15'd0, out_valid, out_pixel}, {15'd0, 1'b1, model(wb, 5, 0, 0, 0, 0)});
        @(negedge clk);
        check("R13 drained", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) pal_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_table_port();
        t_indexed();
        t_orders();
        t_direct();
        t_swap();
        t_stall();
        t_back_to_back();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule